// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the colour subcarrier phase for an analog television encoder. A 12-bit phase accumulator advances by a coarse step on every pixel clock. Two fractional accumulators sit in a chain behind it, and each has a programmable rollover size that need not be a power of two. Each of them carries one unit into the stage above whenever it rolls over. With this chain, the NTSC and PAL subcarrier to pixel-clock ratios come out exactly using integer arithmetic only. A downstream sine table turns the phase word into the subcarrier waveform.

A field counter watches the field-start strobe. On a selected period of 2, 4 or 8 fields it returns all three accumulators to zero, so the subcarrier phase lines up again with the field sequence. The period can also be set so that no return to zero ever happens. Typical settings are as follows:

- NTSC: coarse step 135, middle step 20800 against size 27456, no fine stage, period of 4 fields.
- PAL: steps 168, 4122 and 67 against sizes 27648 and 625, period of 8 fields.
- NTSC at 4.43 MHz: steps 168, 4093 and 310 against sizes 27456 and 525, never cleared.

Top module: `scdda_phase_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the phase output, both fractional accumulators and the field counter become zero, whatever the other inputs do.
- R2: On each clock, when the coarse stage is enabled, the phase output increases by the 12-bit coarse step, wrapping modulo 4096. When the coarse stage is disabled, no coarse step is added.
- R3: The middle stage is active when its enable is high and its size is nonzero. Each clock it forms accumulator + step + carry from the fine stage. If that sum is at least the size, it stores the sum minus the size and adds exactly one extra unit to the phase in the same clock. Otherwise it stores the sum. With step < size, the accumulator stays below the size.
- R4: The fine stage follows the same rule against its own size, and its carry feeds the middle stage. A fine size of zero makes the fine stage inert, even when it is enabled.
- R5: An inactive fractional stage holds its accumulator and produces no carry. When the middle stage is inactive, carries from the fine stage are lost.
- R6: Period code 0, 1 or 2 clears the accumulators on every 2nd, 4th or 8th field-start strobe, counted since reset or since the last clear. The phase reads 0 in the clock after the clearing strobe, and accumulation then resumes from zero.
- R7: Period code 3 never clears the accumulators, however many field-start strobes arrive.
- R8: A clear takes priority over the coarse step and over any carry in the same clock. The phase and both fractional accumulators are then exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start_i | input | 1 | One-clock strobe at the start of each field |
| dda1_en_i | input | 1 | Coarse stage enable |
| dda2_en_i | input | 1 | Middle fractional stage enable |
| dda3_en_i | input | 1 | Fine fractional stage enable |
| dda1_inc_i | input | 12 | Coarse phase step |
| dda2_inc_i | input | 15 | Middle stage step |
| dda2_size_i | input | 15 | Middle stage rollover size |
| dda3_inc_i | input | 15 | Fine stage step |
| dda3_size_i | input | 15 | Fine stage rollover size |
| reset_period_i | input | 2 | Clear period code: 0=2 fields, 1=4, 2=8, 3=never |
| phase_o | output | 12 | Subcarrier phase word |

## Verification
A field clear and a middle-stage rollover can fall in the same clock. In that clock the clear must win over both the carry and the coarse step. The bench provokes this with a tiny rollover size (step 1, size 2), which makes a carry every other clock, and it places the clearing strobe exactly on a carry clock. It then checks that the phase reads 0 rather than the carried value, and that the next carry arrives two clocks later from a zeroed accumulator. The table runs also compare every clock against a bench model, so clears that happen to meet a carry in the NTSC and PAL settings are judged too.

// File: rtl/scdda_pkg.sv
// Shared definitions for the subcarrier phase generator.
// Assumes: the period code is two bits wide and the longest clear period is 8 fields.
package scdda_pkg;
    localparam int PERIOD_CODE_W = 2;
    localparam int MAX_FIELDS    = 8;

    typedef enum logic [PERIOD_CODE_W-1:0] {
        CLR_EVERY2 = 2'd0,
        CLR_EVERY4 = 2'd1,
        CLR_EVERY8 = 2'd2,
        CLR_NEVER  = 2'd3
    } clr_period_e;
endpackage

// File: rtl/scdda_field_timer.sv
// Counts field-start strobes and raises a clear on the strobe that completes
// the selected period. Assumes: strobes last one clock; the counter wraps
// freely when the period code is CLR_NEVER.
module scdda_field_timer
    import scdda_pkg::*;
#(
    parameter int CODE_W = PERIOD_CODE_W,
    parameter int FIELDS = MAX_FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start_i,
    input  logic [CODE_W-1:0] period_i,
    output logic              clr_o
);
    localparam int CNT_W = $clog2(FIELDS);

    clr_period_e      mode;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign mode = clr_period_e'(period_i);

    // Translate the period code into the last count before a clear.
    always_comb begin
        case (mode)
            CLR_EVERY2: limit = CNT_W'(1);
            CLR_EVERY4: limit = CNT_W'(3);
            CLR_EVERY8: limit = CNT_W'(7);
            default:    limit = '1;
        endcase
    end

    assign clr_o = field_start_i && (mode != CLR_NEVER) && (cnt_q >= limit);

    // Field counter: restart on clear, advance on every other strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr_o)         cnt_q <= '0;
        else if (field_start_i) cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_count_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start_i && !clr_o) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_count_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> cnt_q == '0);
    assert_never_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CLR_NEVER) |-> !clr_o);
endmodule

// File: rtl/scdda_frac_stage.sv
// One fractional accumulator with a programmable rollover size. It adds its
// step plus an incoming carry and, on reaching the size, subtracts it and
// emits one carry. Assumes: step < size; a size of zero makes the stage inert.
module scdda_frac_stage #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] inc_i,
    input  logic [W-1:0] size_i,
    input  logic         carry_i,
    output logic         carry_o
);
    logic         active;
    logic [W:0]   sum;
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_d;

    // Next accumulator value and carry out for this clock.
    always_comb begin
        active  = en_i && (size_i != '0);
        sum     = {1'b0, acc_q} + {1'b0, inc_i} + (W+1)'(carry_i);
        acc_d   = acc_q;
        carry_o = 1'b0;
        if (active) begin
            if (sum >= {1'b0, size_i}) begin
                acc_d   = W'(sum - {1'b0, size_i});
                carry_o = 1'b1;
            end else begin
                acc_d   = sum[W-1:0];
            end
        end
    end

    // Accumulator register with field clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else            acc_q <= acc_d;
    end

    assert_acc_below_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && inc_i < size_i && acc_q < size_i) |=> acc_q < $past(size_i));
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/scdda_phase_gen.sv
// Top of the subcarrier phase generator: a coarse phase accumulator fed by a
// chain of fractional stages (middle, then fine), cleared on a field period.
// Assumes: one phase update per clock; the sine lookup lies downstream.
module scdda_phase_gen
    import scdda_pkg::*;
#(
    parameter int PHASE_W = 12,
    parameter int INC1_W  = 12,
    parameter int FRAC_W  = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     field_start_i,
    input  logic                     dda1_en_i,
    input  logic                     dda2_en_i,
    input  logic                     dda3_en_i,
    input  logic [INC1_W-1:0]        dda1_inc_i,
    input  logic [FRAC_W-1:0]        dda2_inc_i,
    input  logic [FRAC_W-1:0]        dda2_size_i,
    input  logic [FRAC_W-1:0]        dda3_inc_i,
    input  logic [FRAC_W-1:0]        dda3_size_i,
    input  logic [PERIOD_CODE_W-1:0] reset_period_i,
    output logic [PHASE_W-1:0]       phase_o
);
    localparam int NSTAGE = 2;   // index 0 = middle stage, 1 = fine stage

    logic              clr;
    logic [FRAC_W-1:0] st_inc  [NSTAGE];
    logic [FRAC_W-1:0] st_size [NSTAGE];
    logic              st_en   [NSTAGE];
    logic              st_cin  [NSTAGE];
    logic              st_cout [NSTAGE];
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_d;

    assign st_inc[0]  = dda2_inc_i;
    assign st_inc[1]  = dda3_inc_i;
    assign st_size[0] = dda2_size_i;
    assign st_size[1] = dda3_size_i;
    assign st_en[0]   = dda2_en_i;
    assign st_en[1]   = dda3_en_i;

    scdda_field_timer u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_start_i(field_start_i),
        .period_i     (reset_period_i),
        .clr_o        (clr)
    );

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == NSTAGE - 1) begin : g_last
            assign st_cin[g] = 1'b0;
        end else begin : g_mid
            assign st_cin[g] = st_cout[g+1];
        end
        scdda_frac_stage #(.W(FRAC_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .en_i   (st_en[g]),
            .inc_i  (st_inc[g]),
            .size_i (st_size[g]),
            .carry_i(st_cin[g]),
            .carry_o(st_cout[g])
        );
    end

    // Next phase: coarse step plus the middle-stage carry, or zero on clear.
    always_comb begin
        if (clr) phase_d = '0;
        else     phase_d = phase_q
                         + (dda1_en_i ? PHASE_W'(dda1_inc_i) : PHASE_W'(0))
                         + PHASE_W'(st_cout[0]);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> phase_o == '0);
    assert_carry_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !dda1_en_i && st_cout[0]) |=> phase_o == $past(phase_o) + PHASE_W'(1));
endmodule

// File: tb/scdda_phase_gen_bench.sv
module scdda_phase_gen_bench;
    localparam int NENT = 6;
    // Columns: period code, enables {e1,e2,e3}, coarse step, middle step and
    // size, fine step and size, field length in clocks, requirement tag.
    localparam int T_CODE [NENT] = '{1, 2, 3, 0, 3, 0};
    localparam int T_EN   [NENT] = '{7, 7, 7, 7, 3, 5};
    localparam int T_INC1 [NENT] = '{135, 168, 168, 100, 50, 77};
    localparam int T_INC2 [NENT] = '{20800, 4122, 4093, 5, 9000, 400};
    localparam int T_SZ2  [NENT] = '{27456, 27648, 27456, 7, 10000, 500};
    localparam int T_INC3 [NENT] = '{0, 67, 310, 3, 0, 3};
    localparam int T_SZ3  [NENT] = '{0, 625, 525, 5, 0, 5};
    localparam int T_FLEN [NENT] = '{23, 29, 17, 11, 19, 13};
    localparam string T_TAG [NENT] = '{"R2 R4 R6", "R3 R4 R6", "R3 R7",
                                       "R4 R6", "R2 R3", "R5"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_start = 1'b0;
    logic        en1 = 1'b0, en2 = 1'b0, en3 = 1'b0;
    logic [11:0] inc1 = '0;
    logic [14:0] inc2 = '0, size2 = '0, inc3 = '0, size3 = '0;
    logic [1:0]  code = '0;
    logic [11:0] phase;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int m_phase, m_acc2, m_acc3, m_cnt;

    always #4 clk = ~clk;

    scdda_phase_gen u_scdda_phase_gen (
        .clk(clk), .rst_n(rst_n), .field_start_i(field_start),
        .dda1_en_i(en1), .dda2_en_i(en2), .dda3_en_i(en3),
        .dda1_inc_i(inc1), .dda2_inc_i(inc2), .dda2_size_i(size2),
        .dda3_inc_i(inc3), .dda3_size_i(size3),
        .reset_period_i(code), .phase_o(phase)
    );

    task automatic check(input string req, input int exp);
        checks++;
        if (int'(phase) !== exp) begin
            failures++;
            $display("FAIL %s: phase=%0d expected=%0d at %0t", req, phase, exp, $time);
        end
    endtask

    // Reference model from the requirements, advanced once per clock.
    task automatic model_tick();
        int c2, c3, s, n2, n3, lim;
        bit clr;
        if (!rst_n) begin
            m_phase = 0; m_acc2 = 0; m_acc3 = 0; m_cnt = 0;
            return;
        end
        lim = (2 << code) - 1;
        clr = field_start && code != 3 && m_cnt >= lim;
        c3 = 0; n3 = m_acc3;
        if (en3 && size3 != 0) begin
            s = m_acc3 + int'(inc3);
            if (s >= int'(size3)) begin n3 = s - int'(size3); c3 = 1; end
            else n3 = s;
        end
        c2 = 0; n2 = m_acc2;
        if (en2 && size2 != 0) begin
            s = m_acc2 + int'(inc2) + c3;
            if (s >= int'(size2)) begin n2 = s - int'(size2); c2 = 1; end
            else n2 = s;
        end
        if (clr) begin
            m_phase = 0; m_acc2 = 0; m_acc3 = 0; m_cnt = 0;
        end else begin
            m_phase = (m_phase + (en1 ? int'(inc1) : 0) + c2) % 4096;
            m_acc2 = n2; m_acc3 = n3;
            if (field_start) m_cnt = (m_cnt + 1) % 8;
        end
    endtask

    // One clock: inputs already set at a falling edge; sample at the next one.
    task automatic step(input bit fs, input string req);
        field_start = fs;
        model_tick();
        @(posedge clk);
        @(negedge clk);
        check(req, m_phase);
    endtask

    task automatic load(input int e);
        code = 2'(T_CODE[e]);
        en1 = T_EN[e][2]; en2 = T_EN[e][1]; en3 = T_EN[e][0];
        inc1 = 12'(T_INC1[e]); inc2 = 15'(T_INC2[e]); size2 = 15'(T_SZ2[e]);
        inc3 = 15'(T_INC3[e]); size3 = 15'(T_SZ3[e]);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with strobes and a live configuration on the inputs.
        load(1);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, "R1");
        check("R1", 0);

        // Table-driven runs, each from a fresh reset.
        for (int e = 0; e < NENT; e++) begin
            rst_n = 1'b0;
            load(e);
            step(1'b0, "R1");
            rst_n = 1'b1;
            for (int c = 1; c <= 600; c++)
                step((c % T_FLEN[e]) == 0, T_TAG[e]);
        end

        // R8: clear lands on a middle-stage carry clock.
        rst_n = 1'b0;
        code = 2'd0; en1 = 1'b0; en2 = 1'b1; en3 = 1'b0;
        inc1 = 12'd9; inc2 = 15'd1; size2 = 15'd2; inc3 = '0; size3 = '0;
        step(1'b0, "R1");
        rst_n = 1'b1;
        step(1'b1, "R8");   // first strobe, acc2=1, no carry
        check("R8", 0);
        step(1'b0, "R3");   // carry -> phase 1
        check("R3", 1);
        step(1'b0, "R8");   // acc2=1
        step(1'b1, "R8");   // carry clock and clearing strobe together
        check("R8", 0);
        step(1'b0, "R8");   // acc2 restarts from zero: no carry
        check("R8", 0);
        step(1'b0, "R3");   // carry from zeroed accumulator
        check("R3", 1);

        // R4: fine size zero with the fine stage enabled has no effect.
        rst_n = 1'b0;
        code = 2'd3; en1 = 1'b0; en2 = 1'b1; en3 = 1'b1;
        inc2 = 15'd0; size2 = 15'd4; inc3 = 15'd7; size3 = 15'd0;
        step(1'b0, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) step(1'b0, "R4");
        check("R4", 0);

        // R2: coarse wrap modulo 4096.
        rst_n = 1'b0;
        en1 = 1'b1; en2 = 1'b0; en3 = 1'b0; inc1 = 12'd4095;
        step(1'b0, "R1");
        rst_n = 1'b1;
        step(1'b0, "R2");
        check("R2", 4095);
        step(1'b0, "R2");
        check("R2", 4094);

        // R1: reset in mid-run.
        rst_n = 1'b0;
        step(1'b0, "R1");
        check("R1", 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule